// File: doc/BRIEF.md
# Trigger Source and Acquire Gate

This block decides when a trigger strobe goes out toward the clock and control interface, and it drives a fixed-length pulse for a front-panel output. Each cycle a control field picks one trigger source: an asynchronous external input, internal logic driven by the anode and cathode valid flags, or a single-cycle strobe from a register-write command. A second field picks the internal condition: both flags together, the anode flag alone, the cathode flag alone, or either flag.

An acquire mode can be switched on. While it is on, the block starts out disarmed. An edge on the asynchronous acquire input arms it, and only the first qualifying event after that is let through. The block then disarms again until the next acquire edge. While acquire mode is off, every qualifying event produces a trigger.

The front-panel pulse lasts 100 ns, which is four cycles of a 40 MHz clock. A trigger that arrives while the pulse is already running still produces its own strobe, but it does not restart or extend the pulse.

Top module: `trig_source_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `trig_out` and `pulse_out` are low.
- R2: With `src_sel`=0 (external), each rising edge of `ext_trig_in` (held at least two cycles) produces exactly one `trig_out` cycle. The strobe rises on the third rising clock edge after the input rises, because of a two-flop synchroniser followed by edge detection.
- R3: With `src_sel`=1 (internal), a cycle where the flags meet `cond_sel` gives `trig_out` high on the next cycle. The `cond_sel` codes are: 0 = anode and cathode both, 1 = anode only, 2 = cathode only, 3 = anode or cathode.
- R4: With `src_sel`=3 (command), a one-cycle `cmd_trig` gives `trig_out` high for one cycle on the next cycle.
- R5: With `src_sel`=2 (reserved), no stimulus produces a trigger or a pulse.
- R6: Each trigger that starts a pulse drives `pulse_out` high for exactly PULSE_NS/CLK_NS cycles (4 by default). The pulse begins in the same cycle as `trig_out`.
- R7: A trigger that arrives while `pulse_out` is high still produces a `trig_out` cycle, but it does not lengthen the pulse.
- R8: With `acq_en`=1, no trigger is issued until a rising edge on `acq_in` (passed through the same synchroniser) arms the block. After arming, only the first qualifying event is issued and the block is disarmed again. This holds for every source.
- R9: With `acq_en`=0, every qualifying event is issued, including events on consecutive cycles.
- R10: A stimulus from a source that `src_sel` does not select produces neither a trigger nor a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Source: 0 external, 1 internal, 2 reserved, 3 command |
| cond_sel | input | 2 | Internal condition: 0 both, 1 anode, 2 cathode, 3 either |
| acq_en | input | 1 | Enables one-shot acquire mode |
| ext_trig_in | input | 1 | Asynchronous external trigger |
| acq_in | input | 1 | Asynchronous acquire arming input |
| cmd_trig | input | 1 | One-cycle command trigger strobe |
| anode_vld | input | 1 | Anode valid flag |
| cathode_vld | input | 1 | Cathode valid flag |
| trig_out | output | 1 | One-cycle trigger strobe |
| pulse_out | output | 1 | Front-panel pulse, fixed width |

## Verification
Some behaviours are checked by the assertions on every cycle. The pulse never runs longer than its nominal width, and it only ever rises together with a trigger. No trigger leaves the block while the reserved source is selected. In acquire mode, no trigger is issued unless an acquire edge came after the previous trigger. Command and coincidence triggers appear one cycle after their cause.

The bench sweeps every source, every condition and every stimulus kind. Only these scenarios can show that exactly one strobe and one four-cycle pulse result and that sources which are not selected are ignored. The same holds for the arming sequence, back-to-back events and the non-extending pulse.

// File: rtl/trig_source_ctrl.sv
module trig_source_ctrl #(
  parameter int CLK_NS   = 25,
  parameter int PULSE_NS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic [1:0] cond_sel,
  input  logic       acq_en,
  input  logic       ext_trig_in,
  input  logic       acq_in,
  input  logic       cmd_trig,
  input  logic       anode_vld,
  input  logic       cathode_vld,
  output logic       trig_out,
  output logic       pulse_out
);
  localparam int PULSE_CYC = PULSE_NS / CLK_NS;
  localparam int CW        = $clog2(PULSE_CYC + 1);

  logic [2:0]    ext_sync, acq_sync;
  logic          armed, trig_q;
  logic [CW-1:0] cnt;
  logic          ext_rise, acq_rise, int_evt, cand, fire;

  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign acq_rise = acq_sync[1] & ~acq_sync[2];

  always_comb begin
    unique case (cond_sel)
      2'd0: int_evt = anode_vld & cathode_vld;
      2'd1: int_evt = anode_vld;
      2'd2: int_evt = cathode_vld;
      default: int_evt = anode_vld | cathode_vld;
    endcase
    unique case (src_sel)
      2'd0: cand = ext_rise;
      2'd1: cand = int_evt;
      2'd3: cand = cmd_trig;
      default: cand = 1'b0;
    endcase
  end

  assign fire = cand & (~acq_en | armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sync <= '0;
      acq_sync <= '0;
      armed    <= 1'b0;
      trig_q   <= 1'b0;
      cnt      <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_trig_in};
      acq_sync <= {acq_sync[1:0], acq_in};
      armed    <= acq_en & (acq_rise | (armed & ~fire));
      trig_q   <= fire;
      if (fire && cnt == '0) cnt <= CW'(PULSE_CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  assign trig_out  = trig_q;
  assign pulse_out = (cnt != '0);
endmodule

// File: rtl/trig_source_ctrl_chk.sv
module trig_source_ctrl_chk #(
  parameter int CLK_NS   = 25,
  parameter int PULSE_NS = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic [1:0] cond_sel,
  input logic       acq_en,
  input logic       acq_in,
  input logic       cmd_trig,
  input logic       anode_vld,
  input logic       cathode_vld,
  input logic       trig_out,
  input logic       pulse_out
);
  localparam int PULSE_CYC = PULSE_NS / CLK_NS;

  logic [7:0] run;
  logic       acq_prev, seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= '0;
      acq_prev <= 1'b0;
      seen     <= 1'b0;
    end else begin
      run      <= pulse_out ? ((run == 8'hFF) ? run : run + 8'd1) : 8'd0;
      acq_prev <= acq_in;
      if (acq_in && !acq_prev) seen <= 1'b1;
      else if (trig_out)       seen <= 1'b0;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!trig_out && !pulse_out));

  a_r6_pulse_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (run < 8'(PULSE_CYC)));

  a_r7_pulse_starts_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> trig_out);

  a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd2 && $stable(src_sel)) |=> !trig_out);

  a_r8_acq_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && trig_out) |-> seen);

  a_r4_cmd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3 && !acq_en && cmd_trig) |=> trig_out);

  a_r3_coincidence: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd1 && cond_sel == 2'd0 && !acq_en && anode_vld && cathode_vld) |=> trig_out);
endmodule

bind trig_source_ctrl trig_source_ctrl_chk #(.CLK_NS(CLK_NS), .PULSE_NS(PULSE_NS)) i_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cond_sel(cond_sel), .acq_en(acq_en),
  .acq_in(acq_in), .cmd_trig(cmd_trig), .anode_vld(anode_vld), .cathode_vld(cathode_vld),
  .trig_out(trig_out), .pulse_out(pulse_out));

// File: tb/test_trig_source_ctrl.sv
module test_trig_source_ctrl;
  localparam int CLK_PERIOD = 25;
  localparam int PULSE_CYC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0, cond_sel = 2'd0;
  logic acq_en = 1'b0, ext_trig_in = 1'b0, acq_in = 1'b0, cmd_trig = 1'b0;
  logic anode_vld = 1'b0, cathode_vld = 1'b0;
  logic trig_out, pulse_out;

  int n_chk = 0, n_err = 0, tcnt = 0, pcnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_source_ctrl i_trig_source_ctrl (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cond_sel(cond_sel), .acq_en(acq_en),
    .ext_trig_in(ext_trig_in), .acq_in(acq_in), .cmd_trig(cmd_trig),
    .anode_vld(anode_vld), .cathode_vld(cathode_vld),
    .trig_out(trig_out), .pulse_out(pulse_out));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tcnt += int'(trig_out);
    pcnt += int'(pulse_out);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // kind 0..3: {cathode,anode} flags; 4 external; 5 command; 6 acquire
  task automatic ev(input int kind);
    if (kind < 4) begin
      anode_vld = kind[0];
      cathode_vld = kind[1];
    end else if (kind == 4) ext_trig_in = 1'b1;
    else if (kind == 5) cmd_trig = 1'b1;
    else acq_in = 1'b1;
    tick();
    anode_vld = 1'b0; cathode_vld = 1'b0; cmd_trig = 1'b0;
    tick();
    ext_trig_in = 1'b0; acq_in = 1'b0;
  endtask

  function automatic int cond_hit(input int cs, input int k);
    bit a = k[0], c = k[1];
    case (cs)
      0: return int'(a & c);
      1: return int'(a);
      2: return int'(c);
      default: return int'(a | c);
    endcase
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 trig in reset", int'(trig_out), 0);
    check("R1 pulse in reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    tick();
    check("R1 trig after reset", int'(trig_out), 0);
    check("R1 pulse after reset", int'(pulse_out), 0);

    // R2 R3 R4 R5 R6 R9 R10: sweep of source, condition and stimulus
    for (int s = 0; s < 4; s++)
      for (int cs = 0; cs < 4; cs++)
        for (int k = 0; k < 6; k++) begin
          int exp;
          src_sel = 2'(s); cond_sel = 2'(cs);
          idle(1);
          tcnt = 0; pcnt = 0;
          ev(k);
          idle(10);
          exp = (s == 0) ? int'(k == 4) :
                (s == 1) ? ((k < 4) ? cond_hit(cs, k) : 0) :
                (s == 3) ? int'(k == 5) : 0;
          check($sformatf("R10 R5 R2 R3 R4 trig src=%0d cond=%0d stim=%0d", s, cs, k), tcnt, exp);
          check($sformatf("R6 pulse src=%0d cond=%0d stim=%0d", s, cs, k), pcnt, PULSE_CYC*exp);
        end

    // R9: three back-to-back internal events
    src_sel = 2'd1; cond_sel = 2'd1;
    tcnt = 0; pcnt = 0;
    anode_vld = 1'b1;
    idle(3);
    anode_vld = 1'b0;
    idle(8);
    check("R9 consecutive triggers", tcnt, 3);

    // R7: second command during pulse does not lengthen it
    src_sel = 2'd3;
    tcnt = 0; pcnt = 0;
    ev(5); ev(5);
    idle(8);
    check("R7 trig count", tcnt, 2);
    check("R7 pulse length", pcnt, PULSE_CYC);

    // R8: acquire mode, internal source
    acq_en = 1'b1; src_sel = 2'd1; cond_sel = 2'd3;
    idle(2);
    tcnt = 0; pcnt = 0;
    ev(1); idle(6);
    check("R8 unarmed no trigger", tcnt, 0);
    ev(6); idle(5);
    ev(1); idle(2); ev(2); idle(2); ev(3); idle(8);
    check("R8 one trigger per arming", tcnt, 1);
    check("R8 pulse per arming", pcnt, PULSE_CYC);
    tcnt = 0;
    ev(6); idle(5);
    ev(2); idle(2); ev(1); idle(8);
    check("R8 rearm gives one more", tcnt, 1);

    // R8: acquire mode, external source
    src_sel = 2'd0;
    tcnt = 0;
    ev(6); idle(5);
    ev(4); idle(4); ev(4); idle(10);
    check("R8 external one per arming", tcnt, 1);

    acq_en = 1'b0;
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule